// File: doc/BRIEF.md
# Serial Baud Rate Divider

This block turns a bus clock into the timing strobes that an asynchronous serial controller runs on. Software writes one byte-wide rate control register. The register holds a 2-bit prescaler code and a 3-bit power-of-two exponent. From these the block builds an input-cycle divisor N, which is the prescaler factor shifted left by the exponent. Every N input cycles it raises an oversample strobe for one cycle. On every sixteenth oversample strobe it also raises a bit strobe, so one bit time lasts 16·N input cycles.

The register reads back exactly as written. Any write restarts both dividers from zero, so each new setting begins on a clean phase. A synchronous reset loads zero, which gives the fastest setting: an oversample strobe on every cycle and a bit strobe every 16 cycles. When the boot-mode pin is high during reset, the register instead loads 0x33, a preset slow rate for boot loaders. The block has no data stream, so all of its pins are plain control and status signals with no valid/ready handshake.

Top module: `baud_rate_gen`

## Requirements
- R1: The prescaler code sits in register bits [5:4]. Code 00 gives a factor of 1, 01 gives 3, 10 gives 4 and 11 gives 13.
- R2: Register bits [2:0] hold an exponent e. The divisor is N = factor × 2^e, which ranges from 1 to 1664 input cycles.
- R3: `os_tick` is high for exactly one cycle in every N cycles. When N = 1 it stays high on every cycle.
- R4: `bit_tick` is high only together with `os_tick`, once in every 16 oversample strobes, so once every 16·N cycles.
- R5: A write restarts both dividers at the clock edge that captures it. Counting that edge as the start, the first `os_tick` appears in cycle N after it and the first `bit_tick` in cycle 16·N. This holds even if the write lands part-way through a period.
- R6: A reset with `boot_mode` low clears the register to 0x00. `os_tick` is then high every cycle and `bit_tick` is high every 16th cycle, counted from the edge where reset ends.
- R7: A reset with `boot_mode` high loads 0x33, which selects factor 13 with exponent 3 (N = 104).
- R8: `rd_data` returns the last byte written, including bits 7, 6 and 3. Those three bits have no effect on the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_mode | input | 1 | Selects the boot preset value while reset is active |
| wr_en | input | 1 | Writes `wr_data` into the rate register at the clock edge |
| wr_data | input | 8 | New rate register value |
| rd_data | output | 8 | Current rate register value |
| os_tick | output | 1 | Oversample strobe, one cycle long, once every N cycles |
| bit_tick | output | 1 | Bit-time strobe, one cycle long, once every 16·N cycles |

## Verification
Each write or reset release is treated as cycle zero. The register value is due on `rd_data` one edge after the write, and the bench compares it at the very next falling edge. From there the bench counts falling-edge samples: the k-th sample reflects k−1 counting edges. It expects the first `os_tick` at sample N, every later one at a multiple of N, and the single `bit_tick` at sample 16·N, with exactly 16 oversample strobes in that window. A write issued partway through a period is measured from its own capturing edge, which shows that the old phase has been discarded.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
package baud_pkg;
  // Width of the largest prescaler factor (13)
  localparam int FACTOR_W = 4;

  // Prescaler code to non-power-of-two factor
  function automatic logic [FACTOR_W-1:0] factor_of(input logic [1:0] code);
    case (code)
      2'b00:   factor_of = 4'd1;
      2'b01:   factor_of = 4'd3;
      2'b10:   factor_of = 4'd4;
      default: factor_of = 4'd13;
    endcase
  endfunction
endpackage

// File: rtl/baud_reg.sv
`timescale 1ns/1ps
// Rate control register with a reset value that depends on boot mode
module baud_reg #(
  parameter int             REG_W      = 8,
  parameter logic [REG_W-1:0] BOOT_VALUE = 8'h33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q <= boot_mode ? BOOT_VALUE : '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/baud_decode.sv
`timescale 1ns/1ps
// Computes divisor minus one: (factor << exponent) - 1
module baud_decode
  import baud_pkg::*;
#(
  parameter int RATE_W = 3,
  parameter int DIV_W  = FACTOR_W + (1 << RATE_W) - 1
) (
  input  logic [1:0]        presc_code,
  input  logic [RATE_W-1:0] rate_exp,
  output logic [DIV_W-1:0]  div_m1
);
  logic [DIV_W-1:0] base;
  logic [DIV_W-1:0] div;

  always_comb begin
    base   = {{(DIV_W-FACTOR_W){1'b0}}, factor_of(presc_code)};
    div    = base << rate_exp;
    div_m1 = div - DIV_W'(1);
  end
endmodule

// File: rtl/mod_counter.sv
`timescale 1ns/1ps
// Modulo counter: advances on step, wraps after reaching last, clear wins
module mod_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] last,
  output logic         wrap
);
  logic [W-1:0] cnt;

  assign wrap = step && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (wrap)       cnt <= '0;
    else if (step)       cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/baud_rate_gen.sv
`timescale 1ns/1ps
module baud_rate_gen #(
  parameter int             REG_W      = 8,
  parameter int             RATE_W     = 3,
  parameter int             PRESC_LSB  = 4,
  parameter int             RATE_LSB   = 0,
  parameter int             OS_PER_BIT = 16,
  parameter logic [REG_W-1:0] BOOT_VALUE = 8'h33
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boot_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             os_tick,
  output logic             bit_tick
);
  localparam int DIV_W = baud_pkg::FACTOR_W + (1 << RATE_W) - 1;
  localparam int BIT_W = $clog2(OS_PER_BIT);

  logic [REG_W-1:0] baud_q;
  logic [DIV_W-1:0] div_m1;
  logic             os_wrap;
  logic             bit_wrap;

  baud_reg #(.REG_W(REG_W), .BOOT_VALUE(BOOT_VALUE)) u_reg (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode),
    .wr_en(wr_en), .wr_data(wr_data), .q(baud_q)
  );

  baud_decode #(.RATE_W(RATE_W), .DIV_W(DIV_W)) u_dec (
    .presc_code(baud_q[PRESC_LSB +: 2]),
    .rate_exp(baud_q[RATE_LSB +: RATE_W]),
    .div_m1(div_m1)
  );

  // Oversample divider: counts every input cycle
  mod_counter #(.W(DIV_W)) u_os (
    .clk(clk), .rst_n(rst_n), .clear(wr_en), .step(1'b1),
    .last(div_m1), .wrap(os_wrap)
  );

  // Bit divider: counts oversample strobes
  mod_counter #(.W(BIT_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .clear(wr_en), .step(os_wrap),
    .last(BIT_W'(OS_PER_BIT - 1)), .wrap(bit_wrap)
  );

  assign rd_data  = baud_q;
  assign os_tick  = os_wrap;
  assign bit_tick = bit_wrap;
endmodule

// File: rtl/baud_rate_gen_chk.sv
`timescale 1ns/1ps
module baud_rate_gen_chk #(
  parameter int REG_W = 8,
  parameter int DIV_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             os_tick,
  input logic             bit_tick,
  input logic [DIV_W-1:0] div_m1
);
  // R4: a bit strobe never occurs without an oversample strobe
  a_r4_bit_in_os: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  // R4: bit strobes never fall on back-to-back cycles
  a_r4_bit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !wr_en) |=> !bit_tick);

  // R3: the oversample strobe lasts one cycle when the divisor exceeds one
  a_r3_os_single: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && !wr_en && div_m1 != '0) |=> !os_tick);

  // R5: the cycle after a write carries no bit strobe
  a_r5_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !bit_tick);

  // R8: a written byte appears on the read port on the next cycle
  a_r8_readback: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data)));

  // R8: without a write the register holds its value
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && rst_n) |=> $stable(rd_data));
endmodule

bind baud_rate_gen baud_rate_gen_chk #(.REG_W(REG_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .os_tick(os_tick), .bit_tick(bit_tick), .div_m1(div_m1)
);

// File: tb/test_baud_rate_gen.sv
`timescale 1ns/1ps
module test_baud_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_mode = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       os_tick;
  logic       bit_tick;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  baud_rate_gen i_baud_rate_gen (
    .clk(clk), .rst_n(rst_n), .boot_mode(boot_mode), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  // Vectors: register byte and expected divisor N (R1, R2)
  localparam int NV = 10;
  localparam logic [7:0] V_DATA [NV] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h01,
                                         8'h12, 8'h27, 8'h37, 8'hC8, 8'h0F};
  localparam int         V_DIV  [NV] = '{1, 3, 4, 13, 2, 12, 512, 1664, 1, 128};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the first falling edge after the restarting edge (sample 1)
  task automatic measure(input int n, input string req);
    int first_os = 0, os_cnt = 0, bad_os = 0, bit_at = 0, bit_cnt = 0;
    for (int k = 1; k <= 16 * n; k++) begin
      if (os_tick) begin
        os_cnt++;
        if (first_os == 0) first_os = k;
        if (k % n != 0) bad_os++;
      end
      if (bit_tick) begin
        bit_cnt++;
        bit_at = k;
      end
      if (k < 16 * n) @(negedge clk);
    end
    check(first_os == n, {req, " first os_tick (R3 R5)"}, first_os, n);
    check(os_cnt == 16 && bad_os == 0, {req, " os_tick spacing (R3)"}, os_cnt * 1000 + bad_os, 16000);
    check(bit_cnt == 1 && bit_at == 16 * n, {req, " bit_tick position (R4 R5)"}, bit_at, 16 * n);
  endtask

  task automatic write_reg(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic boot);
    @(negedge clk);
    rst_n = 1'b0;
    boot_mode = boot;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    boot_mode = 1'b0;
  endtask

  initial begin
    // R6: plain reset
    do_reset(1'b0);
    check(rd_data == 8'h00, "R6 reset value", rd_data, 8'h00);
    measure(1, "R6 reset rate");

    // Table walk covering R1, R2, R8
    for (int i = 0; i < NV; i++) begin
      write_reg(V_DATA[i]);
      check(rd_data == V_DATA[i], "R8 readback", rd_data, V_DATA[i]);
      measure(V_DIV[i], "R1 R2 vector");
    end

    // R5: a write in the middle of a period restarts the phase
    write_reg(8'h30);
    repeat (5) @(negedge clk);
    write_reg(8'h30);
    measure(13, "R5 mid-period rewrite");

    // R5: a change of rate mid-period
    write_reg(8'h27);
    repeat (100) @(negedge clk);
    write_reg(8'h11);
    measure(6, "R5 rate change");

    // R8: ignored bits 7, 6, 3 with a slow setting
    write_reg(8'hFB);
    check(rd_data == 8'hFB, "R8 ignored bits readback", rd_data, 8'hFB);
    measure(104, "R8 ignored bits rate");

    // R7: boot-mode reset preset
    do_reset(1'b1);
    check(rd_data == 8'h33, "R7 boot value", rd_data, 8'h33);
    measure(104, "R7 boot rate");

    // R6: reset after a non-zero setting returns to zero
    write_reg(8'h25);
    do_reset(1'b0);
    check(rd_data == 8'h00, "R6 reset after write", rd_data, 8'h00);
    measure(1, "R6 rate after reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule